// File: doc/BRIEF.md
# Programmable-Modulus Sigma-Delta Divide Ratio Generator

This block produces, once per reference clock cycle, the integer division value for a fractional-N feedback divider. It takes an integer part and a fraction whose numerator and denominator are both programmable, so the denominator does not have to be a power of two. A third-order cascade of three first-order accumulators turns these into a stream of integers that stay close to the integer part and whose long-run average is the integer part plus the fraction. Each accumulator wraps at the programmed modulus.

The configuration fields are sampled into shadow registers only when `load` is pulsed. The modulator state clears on that same edge, so a change made in the middle of a sequence always restarts it from a known point. If the fraction is out of range, or the modulus is too small to make a fraction, the block switches to integer mode and holds the integer part. An optional dither bit, taken from a 21-bit maximal-length pseudo-random sequence, is added to the first accumulator input. This breaks up the short repeat pattern that the plain modulator produces.

Top module: `sdm_ratio_gen`

## Requirements
- R1: After reset, `div_valid` and `div_out` are 0, and they stay 0 until the first `load` pulse.
- R2: On the edge where `load` is high, `int_in`, `frac_in`, `mod_in` and `dither_en` are captured and all modulator state clears. `div_valid` is 0 after that edge and 1 from the following edge on. The first value produced after a load with `dither_en` = 0 equals INT.
- R3: In fractional mode, each output minus INT lies in the range -3 to +4. The output is INT + c1 + (c2 - c2 of the previous cycle) + (c3 - 2 x c3 of the previous cycle + c3 from two cycles back), where c1, c2 and c3 are the stage carries.
- R4: With dither off, over any P consecutive outputs taken from the third output after a load onward, the offsets sum to FRAC x P / MOD. Here P is the repeat length of R5.
- R5: With dither off and FRAC coprime to MOD, the output sequence from the third output onward repeats with period P, which depends on MOD:
  - P = 6 x MOD when MOD is a multiple of 6.
  - P = 2 x MOD when MOD is even but not a multiple of 3.
  - P = 3 x MOD when MOD is a multiple of 3 but odd.
  - P = MOD otherwise.
- R6: When the captured MOD is 0 or 1, or the captured FRAC is MOD or more, every output equals INT, whether dither is on or off.
- R7: With dither on, the first accumulator input is FRAC plus the least significant bit of a 21-bit LFSR. The LFSR uses the polynomial x^21 + x^19 + 1 and restarts at 1 on each load. As a result, the sequence no longer repeats with the period P of R5.
- R8: Changes on `int_in`, `frac_in`, `mod_in` and `dither_en` while `load` is low have no effect on `div_out`.
- R9: A `load` in the middle of a sequence restarts it: the outputs that follow are the same as those after a load from the reset state with the same fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock, one output per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| load | input | 1 | Captures the configuration fields and restarts the modulator |
| int_in | input | 16 | Integer part of the divide ratio |
| frac_in | input | 16 | Fraction numerator |
| mod_in | input | 16 | Fraction denominator (modulus) |
| dither_en | input | 1 | Adds the pseudo-random bit to the first stage input |
| div_out | output | 17 | Divide value for the current cycle, INT plus the signed offset |
| div_valid | output | 1 | High on every cycle that `div_out` carries a modulator value |

## Verification
The bench uses the default parameters: 16-bit fields, a 4-bit signed offset and a 21-bit LFSR. At these widths it can load modulus values of up to a few hundred from every divisibility class, together with random coprime numerators, so that both the full repeat length and the exact offset sum fit inside a short capture window. The same widths also reach the integer-mode boundaries (modulus 0 and 1, numerator equal to or above the modulus). They allow dither to be checked against the plain period and a mid-sequence reload to be compared with a fresh start.

// File: rtl/sdm_ratio_gen.sv
module sdm_ratio_gen #(
  parameter int INT_W    = 16,
  parameter int FRAC_W   = 16,
  parameter int LFSR_W   = 21,
  parameter int LFSR_TAP = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [INT_W-1:0] int_in,
  input  logic [FRAC_W-1:0] frac_in,
  input  logic [FRAC_W-1:0] mod_in,
  input  logic             dither_en,
  output logic [INT_W:0]   div_out,
  output logic             div_valid
);
  localparam int OFF_W = 4;

  logic [INT_W-1:0]  int_s;
  logic [FRAC_W-1:0] frac_s, mod_s;
  logic              dith_s, active;
  logic [FRAC_W-1:0] acc1, acc2, acc3;
  logic              c2p, c3p, c3pp;
  logic [LFSR_W-1:0] lfsr;

  function automatic logic [FRAC_W:0] wrap_add(input logic [FRAC_W-1:0] a,
                                                input logic [FRAC_W:0] b,
                                                input logic [FRAC_W-1:0] m);
    logic [FRAC_W+1:0] s;
    s = {2'b00, a} + {1'b0, b};
    if (s >= {2'b00, m}) begin
      s = s - {2'b00, m};
      return {1'b1, s[FRAC_W-1:0]};
    end
    return {1'b0, s[FRAC_W-1:0]};
  endfunction

  wire int_mode = (mod_s < 2) || (frac_s >= mod_s);

  wire [FRAC_W:0] x1  = {1'b0, frac_s} + {{FRAC_W{1'b0}}, dith_s & lfsr[0]};
  wire [FRAC_W:0] st1 = wrap_add(acc1, x1, mod_s);
  wire [FRAC_W:0] st2 = wrap_add(acc2, {1'b0, st1[FRAC_W-1:0]}, mod_s);
  wire [FRAC_W:0] st3 = wrap_add(acc3, {1'b0, st2[FRAC_W-1:0]}, mod_s);
  wire c1 = st1[FRAC_W];
  wire c2 = st2[FRAC_W];
  wire c3 = st3[FRAC_W];

  wire [OFF_W-1:0] off = OFF_W'(c1) + OFF_W'(c2) - OFF_W'(c2p) + OFF_W'(c3)
                       - OFF_W'({c3p, 1'b0}) + OFF_W'(c3pp);
  wire [INT_W:0] next_div = {1'b0, int_s} + {{(INT_W+1-OFF_W){off[OFF_W-1]}}, off};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      int_s <= '0; frac_s <= '0; mod_s <= '0; dith_s <= 1'b0; active <= 1'b0;
      acc1 <= '0; acc2 <= '0; acc3 <= '0;
      c2p <= 1'b0; c3p <= 1'b0; c3pp <= 1'b0;
      lfsr <= LFSR_W'(1);
      div_out <= '0; div_valid <= 1'b0;
    end else if (load) begin
      int_s <= int_in; frac_s <= frac_in; mod_s <= mod_in; dith_s <= dither_en;
      active <= 1'b1;
      acc1 <= '0; acc2 <= '0; acc3 <= '0;
      c2p <= 1'b0; c3p <= 1'b0; c3pp <= 1'b0;
      lfsr <= LFSR_W'(1);
      div_valid <= 1'b0;
    end else if (active) begin
      div_valid <= 1'b1;
      lfsr <= {lfsr[LFSR_W-2:0], lfsr[LFSR_W-1] ^ lfsr[LFSR_TAP-1]};
      if (int_mode) begin
        acc1 <= '0; acc2 <= '0; acc3 <= '0;
        c2p <= 1'b0; c3p <= 1'b0; c3pp <= 1'b0;
        div_out <= {1'b0, int_s};
      end else begin
        acc1 <= st1[FRAC_W-1:0];
        acc2 <= st2[FRAC_W-1:0];
        acc3 <= st3[FRAC_W-1:0];
        c2p <= c2; c3p <= c3; c3pp <= c3p;
        div_out <= next_div;
      end
    end
  end

  assert_offset_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    active && !int_mode |-> ($signed(off) >= -4'sd3 && $signed(off) <= 4'sd4));

  assert_acc_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    active && !int_mode |-> (acc1 < mod_s && acc2 < mod_s && acc3 < mod_s));

  assert_int_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    active && int_mode && !load |=> div_out == {1'b0, $past(int_s)});

  assert_load_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!div_valid && active && acc1 == '0 && acc3 == '0));

  assert_shadow_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(mod_s) && $stable(frac_s) && $stable(int_s) && $stable(dith_s)));

  assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> (!div_valid && div_out == '0));
endmodule

// File: tb/test_sdm_ratio_gen.sv
`timescale 1ns/1ps
module test_sdm_ratio_gen;
  logic clk = 1'b0, rst_n = 1'b0, load = 1'b0, dither_en = 1'b0;
  logic [15:0] int_in = '0, frac_in = '0, mod_in = '0;
  logic [16:0] div_out;
  logic div_valid;

  int tests = 0, fails = 0;
  int smp [0:3999];
  int refs [0:127];

  sdm_ratio_gen i_sdm_ratio_gen (.clk, .rst_n, .load, .int_in, .frac_in, .mod_in,
                                 .dither_en, .div_out, .div_valid);

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int period_of(input int m);
    if (m % 6 == 0) return 6 * m;
    if (m % 2 == 0) return 2 * m;
    if (m % 3 == 0) return 3 * m;
    return m;
  endfunction

  function automatic int gcd(input int a, input int b);
    int x = a, y = b, t;
    while (y != 0) begin t = x % y; x = y; y = t; end
    return x;
  endfunction

  task automatic run(input int iv, input int f, input int m, input bit d,
                     input int n, input bit scramble);
    @(negedge clk);
    int_in = 16'(iv); frac_in = 16'(f); mod_in = 16'(m); dither_en = d; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
    chk(div_valid == 1'b0, "R2 valid low after load", int'(div_valid), 0);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (k == 0) chk(div_valid == 1'b1, "R2 valid high", int'(div_valid), 1);
      smp[k] = int'(div_out);
      if (scramble) begin
        int_in = 16'($urandom); frac_in = 16'($urandom);
        mod_in = 16'($urandom); dither_en = 1'($urandom);
      end
    end
  endtask

  task automatic frac_case(input int iv, input int f, input int m);
    int p = period_of(m);
    int bad = 0, mism = 0, sum = 0, worst = 0;
    run(iv, f, m, 1'b0, 2 + 2 * p, 1'b0);
    chk(smp[0] == iv, "R2 first value", smp[0], iv);
    for (int k = 0; k < 2 + 2 * p; k++)
      if (smp[k] - iv < -3 || smp[k] - iv > 4) begin bad++; worst = smp[k] - iv; end
    chk(bad == 0, "R3 offset range", worst, 0);
    for (int k = 2; k < 2 + p; k++) begin
      if (smp[k] != smp[k + p]) mism++;
      sum += smp[k] - iv;
    end
    chk(mism == 0, "R5 repeat length", mism, 0);
    chk(sum == f * p / m, "R4 offset sum", sum, f * p / m);
  endtask

  task automatic int_case(input int iv, input int f, input int m, input bit d);
    int bad = 0, last = 0;
    run(iv, f, m, d, 40, 1'b0);
    for (int k = 0; k < 40; k++) if (smp[k] != iv) begin bad++; last = smp[k]; end
    chk(bad == 0, "R6 integer mode", bad == 0 ? iv : last, iv);
  endtask

  initial begin
    void'($urandom(32'd5150));
    repeat (5) @(negedge clk);
    chk(div_valid == 1'b0 && div_out == '0, "R1 reset state", int'(div_out), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(div_valid == 1'b0 && div_out == '0, "R1 idle before load", int'(div_out), 0);

    frac_case(1000, 5, 12);
    frac_case(2000, 4, 9);
    frac_case(300, 5, 18);
    frac_case(777, 3, 7);
    frac_case(64000, 3, 10);
    frac_case(150, 7, 25);
    frac_case(500, 299, 300);
    for (int i = 0; i < 8; i++) begin
      int m, f, cls = i % 4;
      bit okc;
      do begin
        m = 20 + $urandom_range(280);
        case (cls)
          0: okc = (m % 6 == 0);
          1: okc = (m % 2 == 0) && (m % 3 != 0);
          2: okc = (m % 3 == 0) && (m % 2 != 0);
          default: okc = (m % 2 != 0) && (m % 3 != 0);
        endcase
      end while (!okc);
      do f = 1 + $urandom_range(m - 2); while (gcd(f, m) != 1);
      frac_case(100 + $urandom_range(60000), f, m);
    end

    int_case(4321, 0, 1, 1'b0);
    int_case(4321, 5, 0, 1'b0);
    int_case(999, 50, 50, 1'b0);
    int_case(999, 60, 50, 1'b1);

    begin
      int p = period_of(30), mism = 0, bad = 0;
      run(5000, 7, 30, 1'b1, 2 + 2 * p, 1'b0);
      for (int k = 2; k < 2 + p; k++) if (smp[k] != smp[k + p]) mism++;
      chk(mism > 0, "R7 dither breaks period", mism, 1);
      for (int k = 0; k < 2 + 2 * p; k++) if (smp[k] - 5000 < -3 || smp[k] - 5000 > 4) bad++;
      chk(bad == 0, "R3 offset range with dither", bad, 0);
    end

    begin
      int mism = 0;
      run(3333, 3, 14, 1'b0, 100, 1'b0);
      for (int k = 0; k < 100; k++) refs[k] = smp[k];
      run(3333, 3, 14, 1'b0, 100, 1'b1);
      for (int k = 0; k < 100; k++) if (smp[k] != refs[k]) mism++;
      chk(mism == 0, "R8 inputs ignored without load", mism, 0);
      run(3333, 3, 14, 1'b0, 37, 1'b0);
      run(3333, 3, 14, 1'b0, 100, 1'b0);
      mism = 0;
      for (int k = 0; k < 100; k++) if (smp[k] != refs[k]) mism++;
      chk(mism == 0, "R9 reload restarts sequence", mism, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    tests++; fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule